// File: doc/BRIEF.md
# SPI Target Byte Framer with Hold

This block is the serial front end of a byte-organised memory target. It runs in a fast system clock domain and watches a serial clock, a data input, an active-low select and an active-low pause line. All four arrive asynchronously and pass through two-flop synchronisers. Incoming bits are gathered most-significant first. Each finished byte goes to a downstream decoder together with a one-cycle strobe. Alongside, the block shifts out a byte that the core supplies at every byte boundary.

The data output comes with an output-enable that stands in for a high-impedance driver. The enable is low whenever the target is not selected or is paused. A pause freezes the bit position and both shift registers. It starts and ends only while the serial clock is low, so the transfer resumes exactly where it stopped. After reset the block answers nothing until it sees the select line go from high to low. The block only frames bytes and tracks the bit position. It does not decode opcodes. The serial clock must run at no more than a quarter of the system clock.

Top module: `spi_target_fe`

## Requirements
- R1: Data-input bits are captured at each rising serial-clock edge, most-significant bit first; after the 8th rising edge of a byte, `rx_byte_o` holds the eight captured bits with the first-captured bit in bit 7.
- R2: `rx_valid_o` is high for exactly one system clock per completed byte and never pulses for a partial byte.
- R3: `so_o` changes only after a falling serial-clock edge. At the falling edge that follows a byte's 8th rising edge, bit 7 of `tx_byte_i` is loaded. The following byte's first seven falling edges present bits 6 down to 0.
- R4: While the select input is high, `so_oe_o` is 0, `bit_pos_o` is 0 and any partly received byte is discarded.
- R5: After reset, no bit is counted, no byte is reported and `so_oe_o` stays 0 until a high-to-low select transition is seen. A select that is already low at reset does not count.
- R6: While paused, `so_oe_o` is 0 and serial-clock and data-input activity has no effect: `bit_pos_o` and the partly received byte are kept and resume afterwards.
- R7: A change on the pause input while the serial clock is high takes effect only once the serial clock is low. This holds both for entering and for leaving a pause.
- R8: `bit_pos_o` gives the number of bits already received in the current byte (0 to 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock (asynchronous) |
| si_i | input | 1 | Serial data in |
| cs_n_i | input | 1 | Active-low select |
| hold_n_i | input | 1 | Active-low pause |
| tx_byte_i | input | 8 | Byte to shift out next, sampled at the byte-boundary falling edge |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for `so_o` (0 = high impedance) |
| rx_byte_o | output | 8 | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| bit_pos_o | output | 3 | Bits received in the current byte |

## Verification
A serial pin change shows up in the system domain after two synchroniser flops and one edge-history flop. So the byte strobe and an `so_o` update come three system clocks after the serial edge that causes them. The enable and `bit_pos_o` settle within the same three clocks. The bench holds each serial-clock phase for four system clocks and samples on the falling system-clock edge only at the end of a phase, when every result is due. Received bytes are checked by a queue-based monitor that is tied to the strobe rather than to a fixed cycle. A strobe that arrives with an empty queue is itself a miscompare.

// File: rtl/spi_target_fe.sv
module spi_target_fe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck_i,
  input  logic         si_i,
  input  logic         cs_n_i,
  input  logic         hold_n_i,
  input  logic [W-1:0] tx_byte_i,
  output logic         so_o,
  output logic         so_oe_o,
  output logic [W-1:0] rx_byte_o,
  output logic         rx_valid_o,
  output logic [$clog2(W)-1:0] bit_pos_o
);
  localparam int CW = $clog2(W);

  logic [1:0] sck_m, si_m, cs_m, hold_m;
  logic sck_q, cs_q, armed, held;
  logic [CW-1:0] bit_pos;
  logic [W-1:0] rx_sr, tx_sr;
  logic so_q;

  wire sck_s  = sck_m[1];
  wire si_s   = si_m[1];
  wire cs_s   = cs_m[1];
  wire hold_s = hold_m[1];

  wire cs_fall = cs_q & ~cs_s;
  wire active  = armed & ~cs_s;
  wire run     = active & ~held;
  wire rise    = run & sck_s & ~sck_q;
  wire fall    = run & ~sck_s & sck_q;
  wire last    = bit_pos == CW'(W-1);
  wire [W-1:0] rx_next = {rx_sr[W-2:0], si_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m  <= '0;
      si_m   <= '0;
      cs_m   <= '0;
      hold_m <= '1;
      sck_q  <= 1'b0;
      cs_q   <= 1'b0;
      armed  <= 1'b0;
      held   <= 1'b0;
    end else begin
      sck_m  <= {sck_m[0], sck_i};
      si_m   <= {si_m[0], si_i};
      cs_m   <= {cs_m[0], cs_n_i};
      hold_m <= {hold_m[0], hold_n_i};
      sck_q  <= sck_s;
      cs_q   <= cs_s;
      if (cs_fall) armed <= 1'b1;
      if (!sck_s) held <= ~hold_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos    <= '0;
      rx_sr      <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (cs_s) begin
        bit_pos <= '0;
      end else if (rise) begin
        rx_sr   <= rx_next;
        bit_pos <= last ? '0 : bit_pos + 1'b1;
        if (last) begin
          rx_byte_o  <= rx_next;
          rx_valid_o <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      so_q  <= 1'b0;
    end else if (fall) begin
      if (bit_pos == '0) begin
        so_q  <= tx_byte_i[W-1];
        tx_sr <= {tx_byte_i[W-2:0], 1'b0};
      end else begin
        so_q  <= tx_sr[W-1];
        tx_sr <= {tx_sr[W-2:0], 1'b0};
      end
    end
  end

  assign so_o      = so_q;
  assign so_oe_o   = run;
  assign bit_pos_o = bit_pos;
endmodule

// File: rtl/spi_target_fe_chk.sv
module spi_target_fe_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sck_s,
  input logic          sck_q,
  input logic          cs_s,
  input logic          armed,
  input logic          held,
  input logic          so_o,
  input logic          rx_valid_o,
  input logic [CW-1:0] bit_pos_o
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  a_r3_so_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so_o) |-> ($past(sck_q) && !$past(sck_s)));

  a_r4_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_pos_o == '0));

  a_r5_unarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !rx_valid_o);

  a_r6_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_s) |=> $stable(bit_pos_o));

  a_r7_hold_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(held) |-> !$past(sck_s));
endmodule

bind spi_target_fe spi_target_fe_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .sck_q(sck_q), .cs_s(cs_s),
  .armed(armed), .held(held), .so_o(so_o), .rx_valid_o(rx_valid_o),
  .bit_pos_o(bit_pos_o)
);

// File: tb/spi_target_fe_tb.sv
module spi_target_fe_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b0, hold_n = 1'b1;
  logic [7:0] tx_byte = '0;
  logic so, so_oe, rx_valid;
  logic [7:0] rx_byte;
  logic [2:0] bit_pos;

  int vectors = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic prev_valid = 1'b0;

  always #4 clk = ~clk;

  spi_target_fe u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .si_i(si), .cs_n_i(cs_n),
    .hold_n_i(hold_n), .tx_byte_i(tx_byte), .so_o(so), .so_oe_o(so_oe),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .bit_pos_o(bit_pos)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R2 R1: monitor pops one expected byte per strobe
  always @(negedge clk) begin
    if (rx_valid) begin
      vectors++;
      if (prev_valid) begin
        errors++;
        $display("FAIL R2: actual strobe width 2 expected 1");
      end else if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: actual strobe with byte %h expected none", rx_byte);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rx_byte !== e) begin
          errors++;
          $display("FAIL R1: actual %h expected %h", rx_byte, e);
        end
      end
    end
    prev_valid <= rx_valid;
  end

  task automatic bit_io(input logic v, input logic chk, input logic e);
    si = v;
    tick(4);
    if (chk) check("R3", {7'b0, so}, {7'b0, e});
    sck = 1'b1;
    tick(4);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] din, input logic chk, input logic [7:0] eso,
                      input logic [7:0] nxt);
    tx_byte = nxt;
    exp_q.push_back(din);
    for (int b = 7; b >= 0; b--) bit_io(din[b], chk, eso[b]);
    tick(4);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check("R4", {7'b0, so_oe}, 8'h00);
    // R5: select low at reset is ignored
    for (int i = 0; i < 8; i++) bit_io(1'b1, 1'b0, 1'b0);
    tick(6);
    check("R5", {7'b0, so_oe}, 8'h00);
    check("R5", {5'b0, bit_pos}, 8'h00);
    cs_n = 1'b1;
    tick(6);
    check("R4", {7'b0, so_oe}, 8'h00);
    cs_n = 1'b0;
    tick(6);
    check("R5", {7'b0, so_oe}, 8'h01);

    xfer(8'h3C, 1'b0, 8'h00, 8'h96);
    xfer(8'hA5, 1'b1, 8'h96, 8'h5A);
    xfer(8'h00, 1'b1, 8'h5A, 8'hFF);
    xfer(8'hFF, 1'b1, 8'hFF, 8'h00);

    // R4: mid-byte deselect discards partial byte
    bit_io(1'b1, 1'b0, 1'b0);
    bit_io(1'b0, 1'b0, 1'b0);
    bit_io(1'b1, 1'b0, 1'b0);
    tick(5);
    check("R8", {5'b0, bit_pos}, 8'h03);
    cs_n = 1'b1;
    tick(6);
    check("R4", {5'b0, bit_pos}, 8'h00);
    check("R4", {7'b0, so_oe}, 8'h00);
    cs_n = 1'b0;
    tick(6);
    xfer(8'hC3, 1'b0, 8'h00, 8'h69);

    // R6: pause with SCK low
    tx_byte = 8'h00;
    exp_q.push_back(8'h6E);
    bit_io(1'b0, 1'b1, 1'b0);
    bit_io(1'b1, 1'b1, 1'b1);
    bit_io(1'b1, 1'b1, 1'b1);
    tick(4);
    hold_n = 1'b0;
    tick(6);
    check("R6", {7'b0, so_oe}, 8'h00);
    for (int i = 0; i < 3; i++) begin
      si = ~si; tick(4); sck = 1'b1; tick(4); sck = 1'b0;
    end
    tick(5);
    check("R6", {5'b0, bit_pos}, 8'h03);
    hold_n = 1'b1;
    tick(6);
    check("R6", {7'b0, so_oe}, 8'h01);
    check("R6", {5'b0, bit_pos}, 8'h03);
    bit_io(1'b0, 1'b1, 1'b0);
    bit_io(1'b1, 1'b1, 1'b1);
    bit_io(1'b1, 1'b1, 1'b0);
    bit_io(1'b1, 1'b1, 1'b0);
    bit_io(1'b0, 1'b1, 1'b1);
    tick(4);

    // R7: pause changes while SCK high are deferred
    tx_byte = 8'h00;
    exp_q.push_back(8'hB1);
    bit_io(1'b1, 1'b0, 1'b0);
    bit_io(1'b0, 1'b0, 1'b0);
    si = 1'b1;
    tick(4);
    sck = 1'b1;
    tick(2);
    hold_n = 1'b0;
    tick(6);
    check("R7", {7'b0, so_oe}, 8'h01);
    sck = 1'b0;
    tick(5);
    check("R7", {7'b0, so_oe}, 8'h00);
    check("R8", {5'b0, bit_pos}, 8'h03);
    si = 1'b0;
    tick(4);
    sck = 1'b1;
    tick(2);
    hold_n = 1'b1;
    tick(6);
    check("R7", {7'b0, so_oe}, 8'h00);
    sck = 1'b0;
    tick(5);
    check("R7", {7'b0, so_oe}, 8'h01);
    check("R6", {5'b0, bit_pos}, 8'h03);
    bit_io(1'b1, 1'b0, 1'b0);
    bit_io(1'b0, 1'b0, 1'b0);
    bit_io(1'b0, 1'b0, 1'b0);
    bit_io(1'b0, 1'b0, 1'b0);
    bit_io(1'b1, 1'b0, 1'b0);
    tick(6);
    cs_n = 1'b1;
    tick(6);
    check("R2", exp_q.size() == 0 ? 8'h00 : 8'h01, 8'h00);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule